// File: doc/BRIEF.md
# Debug Variable Trace and Override Unit

This unit takes the place of one state register of a design under debug. On every cycle in which the design's clock enable is high, it loads the register's next value and pushes the value being replaced into a circular history store. A debug controller can read the live value at any time. It can also read any recorded past value by its age. It can load a one-time override value, or steer the register onto an alternate source for as long as it wishes.

It can also roll the register back. A rewind of n steps throws away the n newest history entries and restores the value the register held n steps earlier. The rewind is honoured only when those n steps are still recorded. The occupancy of the store is exported together with a high-water flag, so the controller can hold the design's clock enable low before old history is overwritten. A flush request tells the unit that the history has been collected and may be treated as empty.

Top module: `dbg_var_unit`

## Requirements
- R1: After reset, varOut equals RESET_VAL (0), fillLevel is 0, and highWater and rewindErr are 0.
- R2: On an edge with clkEn high, varOut takes varIn (selAlt low) and the previous varOut is recorded, raising fillLevel by one. With clkEn low and no request, varOut and fillLevel hold.
- R3: While selAlt is high, every enabled edge loads altSrc instead of varIn. selAlt has no effect on edges with clkEn low.
- R4: forceReq loads forceVal into varOut on the next edge whatever clkEn is. If clkEn is also high, the previous value is still recorded.
- R5: histOut shows the entry of age rdOffset, where 0 is the newest recorded value. histValid is 1 exactly when rdOffset < fillLevel.
- R6: A rewind with 1 <= rewindN <= fillLevel loads varOut with the entry of age rewindN-1 and lowers fillLevel by rewindN. No capture takes place on that edge, and forceReq and flushReq are ignored on it.
- R7: A rewind with rewindN = 0 or rewindN > fillLevel is refused. rewindErr is 1 for the following cycle only, and the rest of that cycle behaves as if no rewind had been asked.
- R8: fillLevel saturates at DEPTH (64). A capture when the store is full overwrites the oldest entry.
- R9: highWater is 1 exactly when fillLevel >= DEPTH-4 (60).
- R10: flushReq sets fillLevel to 0, or to 1 when a capture happens on the same edge. varOut is not changed by the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Design clock enable; a high cycle is one design step |
| varIn | input | WIDTH | Next value from the design logic |
| altSrc | input | WIDTH | Alternate user-supplied source |
| selAlt | input | 1 | Select altSrc as the register source |
| forceReq | input | 1 | One-shot override request |
| forceVal | input | WIDTH | Override value |
| rewindReq | input | 1 | Rewind request |
| rewindN | input | CW | Number of steps to rewind |
| flushReq | input | 1 | Mark history as collected |
| rdOffset | input | AW | Age of the history entry to read |
| varOut | output | WIDTH | Live register value |
| histOut | output | WIDTH | History entry at rdOffset |
| histValid | output | 1 | rdOffset refers to a recorded entry |
| fillLevel | output | CW | Number of recorded entries |
| highWater | output | 1 | Store is close to full |
| rewindErr | output | 1 | Previous rewind request was refused |

## Verification
Two events can fall on the same edge: a design step (clkEn high) and a rewind request. An accepted rewind must suppress the capture and the next-value load of that step. A refused one must let the step go ahead unchanged. The bench drives both cases on the same edge and checks two things: that varOut holds the restored entry and not varIn, and that fillLevel drops by exactly rewindN with no +1 for the step. A rewind at full occupancy with a simultaneous force request also checks that the rewind takes priority over the override.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_NEXT  = 2'd1,
    SRC_FORCE = 2'd2,
    SRC_HIST  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    capture;
    logic    rewind;
    logic    flush;
    srcSel_e varSrc;
  } dvtStrobe_t;
endpackage

// File: rtl/dvt_ctrl.sv
module dvt_ctrl
  import dvt_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkEn,
  input  logic          forceReq,
  input  logic          rewindReq,
  input  logic [CW-1:0] rewindN,
  input  logic          flushReq,
  input  logic [CW-1:0] fillLevel,
  output dvtStrobe_t    strobe,
  output logic          rewindErr
);
  logic rewOk;

  assign rewOk = rewindReq && (rewindN != '0) && (rewindN <= fillLevel);

  always_comb begin
    strobe.capture = 1'b0;
    strobe.rewind  = 1'b0;
    strobe.flush   = 1'b0;
    strobe.varSrc  = SRC_HOLD;
    if (rewOk) begin
      strobe.rewind = 1'b1;
      strobe.varSrc = SRC_HIST;
    end else begin
      strobe.capture = clkEn;
      strobe.flush   = flushReq;
      if (forceReq)   strobe.varSrc = SRC_FORCE;
      else if (clkEn) strobe.varSrc = SRC_NEXT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rewindErr <= 1'b0;
    else       rewindErr <= rewindReq && !rewOk;
  end
endmodule

// File: rtl/dvt_datapath.sv
module dvt_datapath
  import dvt_pkg::*;
#(
  parameter int          WIDTH     = 16,
  parameter int          DEPTH     = 64,
  parameter int          HWM_GAP   = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dvtStrobe_t       strobe,
  input  logic [WIDTH-1:0] varIn,
  input  logic [WIDTH-1:0] altSrc,
  input  logic             selAlt,
  input  logic [WIDTH-1:0] forceVal,
  input  logic [CW-1:0]    rewindN,
  input  logic [AW-1:0]    rdOffset,
  output logic [WIDTH-1:0] varQ,
  output logic [CW-1:0]    fillLevel,
  output logic [WIDTH-1:0] histOut,
  output logic             histValid,
  output logic             highWater
);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] HWM   = CW'(DEPTH - HWM_GAP);

  logic [WIDTH-1:0] histMem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdIdx;
  logic [AW-1:0]    rewIdx;
  logic [WIDTH-1:0] stepVal;
  logic [CW-1:0]    count;

  assign stepVal = selAlt ? altSrc : varIn;
  assign rdIdx   = wrPtr - AW'(1) - rdOffset;
  assign rewIdx  = wrPtr - rewindN[AW-1:0];

  assign histOut   = histMem[rdIdx];
  assign histValid = {1'b0, rdOffset} < count;
  assign fillLevel = count;
  assign highWater = count >= HWM;

  always_ff @(posedge clk) begin
    if (strobe.capture) histMem[wrPtr] <= varQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      varQ  <= RESET_VAL;
      wrPtr <= '0;
      count <= '0;
    end else begin
      unique case (strobe.varSrc)
        SRC_NEXT:  varQ <= stepVal;
        SRC_FORCE: varQ <= forceVal;
        SRC_HIST:  varQ <= histMem[rewIdx];
        default:   varQ <= varQ;
      endcase
      if (strobe.rewind) begin
        wrPtr <= rewIdx;
        count <= count - rewindN;
      end else if (strobe.capture) begin
        wrPtr <= wrPtr + AW'(1);
        if (strobe.flush)       count <= CW'(1);
        else if (count != FULL) count <= count + CW'(1);
      end else if (strobe.flush) begin
        count <= '0;
      end
    end
  end
endmodule

// File: rtl/dbg_var_unit.sv
module dbg_var_unit
  import dvt_pkg::*;
#(
  parameter int          WIDTH     = 16,
  parameter int          DEPTH     = 64,
  parameter int          HWM_GAP   = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic [WIDTH-1:0] varIn,
  input  logic [WIDTH-1:0] altSrc,
  input  logic             selAlt,
  input  logic             forceReq,
  input  logic [WIDTH-1:0] forceVal,
  input  logic             rewindReq,
  input  logic [CW-1:0]    rewindN,
  input  logic             flushReq,
  input  logic [AW-1:0]    rdOffset,
  output logic [WIDTH-1:0] varOut,
  output logic [WIDTH-1:0] histOut,
  output logic             histValid,
  output logic [CW-1:0]    fillLevel,
  output logic             highWater,
  output logic             rewindErr
);
  dvtStrobe_t strobe;

  dvt_ctrl #(.CW(CW)) ctrlI (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .forceReq(forceReq),
    .rewindReq(rewindReq), .rewindN(rewindN), .flushReq(flushReq),
    .fillLevel(fillLevel), .strobe(strobe), .rewindErr(rewindErr)
  );

  dvt_datapath #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .HWM_GAP(HWM_GAP), .RESET_VAL(RESET_VAL)
  ) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .varIn(varIn),
    .altSrc(altSrc), .selAlt(selAlt), .forceVal(forceVal),
    .rewindN(rewindN), .rdOffset(rdOffset), .varQ(varOut),
    .fillLevel(fillLevel), .histOut(histOut), .histValid(histValid),
    .highWater(highWater)
  );
endmodule

// File: rtl/dbg_var_unit_chk.sv
module dbg_var_unit_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             forceReq,
  input logic [WIDTH-1:0] forceVal,
  input logic             rewindReq,
  input logic [CW-1:0]    rewindN,
  input logic             flushReq,
  input logic [WIDTH-1:0] varOut,
  input logic [CW-1:0]    fillLevel,
  input logic             rewindErr
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !forceReq && !rewindReq && !flushReq) |=> ($stable(varOut) && $stable(fillLevel)));

  // R4
  force_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceReq && !rewindReq) |=> (varOut == $past(forceVal)));

  // R6
  rewind_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rewindReq && rewindN != '0 && rewindN <= fillLevel)
      |=> (fillLevel == $past(fillLevel) - $past(rewindN)) && !rewindErr);

  // R7
  rewind_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rewindReq && (rewindN == '0 || rewindN > fillLevel) && !clkEn && !forceReq && !flushReq)
      |=> rewindErr && $stable(varOut) && $stable(fillLevel));

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CW'(DEPTH));
endmodule

bind dbg_var_unit dbg_var_unit_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) chkI (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .forceReq(forceReq),
  .forceVal(forceVal), .rewindReq(rewindReq), .rewindN(rewindN),
  .flushReq(flushReq), .varOut(varOut), .fillLevel(fillLevel),
  .rewindErr(rewindErr)
);

// File: tb/dbg_var_unit_test.sv
module dbg_var_unit_test;
  localparam int W  = 16;
  localparam int CW = 7;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b0, selAlt = 1'b0, forceReq = 1'b0, rewindReq = 1'b0, flushReq = 1'b0;
  logic [W-1:0] varIn = '0, altSrc = '0, forceVal = '0;
  logic [CW-1:0] rewindN = '0;
  logic [AW-1:0] rdOffset = '0;
  logic [W-1:0] varOut, histOut;
  logic histValid, highWater, rewindErr;
  logic [CW-1:0] fillLevel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_var_unit uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .varIn(varIn), .altSrc(altSrc),
    .selAlt(selAlt), .forceReq(forceReq), .forceVal(forceVal),
    .rewindReq(rewindReq), .rewindN(rewindN), .flushReq(flushReq),
    .rdOffset(rdOffset), .varOut(varOut), .histOut(histOut),
    .histValid(histValid), .fillLevel(fillLevel), .highWater(highWater),
    .rewindErr(rewindErr)
  );

  typedef struct packed {
    logic en; logic alt; logic frc; logic rew; logic [6:0] n;
    logic [15:0] vin; logic [15:0] altV; logic [15:0] frcV;
    logic [15:0] expVar; logic [6:0] expFill; logic expErr;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1,1'b0,1'b0,1'b0,7'd0,16'h0011,16'h0000,16'h0000,16'h0011,7'd1,1'b0}, // R2
    '{1'b1,1'b0,1'b0,1'b0,7'd0,16'h0022,16'h0000,16'h0000,16'h0022,7'd2,1'b0}, // R2
    '{1'b0,1'b1,1'b0,1'b0,7'd0,16'h0099,16'h00AA,16'h0000,16'h0022,7'd2,1'b0}, // R3 alt ignored
    '{1'b1,1'b1,1'b0,1'b0,7'd0,16'h0033,16'h005A,16'h0000,16'h005A,7'd3,1'b0}, // R3
    '{1'b1,1'b1,1'b0,1'b0,7'd0,16'h0034,16'h005B,16'h0000,16'h005B,7'd4,1'b0}, // R3
    '{1'b0,1'b0,1'b1,1'b0,7'd0,16'h0000,16'h0000,16'h0077,16'h0077,7'd4,1'b0}, // R4
    '{1'b1,1'b0,1'b0,1'b0,7'd0,16'h0044,16'h0000,16'h0000,16'h0044,7'd5,1'b0}, // R2
    '{1'b1,1'b0,1'b0,1'b1,7'd2,16'h0055,16'h0000,16'h0000,16'h005A,7'd3,1'b0}, // R6
    '{1'b0,1'b0,1'b0,1'b1,7'd4,16'h0000,16'h0000,16'h0000,16'h005A,7'd3,1'b1}, // R7
    '{1'b0,1'b0,1'b0,1'b1,7'd3,16'h0000,16'h0000,16'h0000,16'h0000,7'd0,1'b0}, // R6
    '{1'b0,1'b0,1'b0,1'b1,7'd1,16'h0000,16'h0000,16'h0000,16'h0000,7'd0,1'b1}, // R7
    '{1'b1,1'b0,1'b0,1'b0,7'd0,16'h0066,16'h0000,16'h0000,16'h0066,7'd1,1'b0}, // R2
    '{1'b0,1'b0,1'b0,1'b1,7'd0,16'h0000,16'h0000,16'h0000,16'h0066,7'd1,1'b1}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    clkEn = 0; selAlt = 0; forceReq = 0; rewindReq = 0; flushReq = 0; rewindN = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 varOut", 32'(varOut), 32'h0);
    chk("R1 fill", 32'(fillLevel), 32'd0);
    chk("R1 highWater", 32'(highWater), 32'd0);
    chk("R1 rewindErr", 32'(rewindErr), 32'd0);

    for (int i = 0; i < 13; i++) begin
      clkEn = VEC[i].en; selAlt = VEC[i].alt; forceReq = VEC[i].frc;
      rewindReq = VEC[i].rew; rewindN = VEC[i].n; varIn = VEC[i].vin;
      altSrc = VEC[i].altV; forceVal = VEC[i].frcV;
      step();
      chk($sformatf("R2-table row %0d varOut", i), 32'(varOut), 32'(VEC[i].expVar));
      chk($sformatf("R6-table row %0d fill", i), 32'(fillLevel), 32'(VEC[i].expFill));
      chk($sformatf("R7-table row %0d err", i), 32'(rewindErr), 32'(VEC[i].expErr));
    end
    idle();

    // R10 flush empties history, value kept
    flushReq = 1; step(); idle();
    rdOffset = '0; #1;
    chk("R10 fill after flush", 32'(fillLevel), 32'd0);
    chk("R10 varOut after flush", 32'(varOut), 32'h66);
    chk("R5 histValid empty", 32'(histValid), 32'd0);

    // R8 / R9 fill to wrap
    for (int j = 1; j <= 70; j++) begin
      clkEn = 1; varIn = 16'(j);
      step();
      if (j == 59) chk("R9 highWater below", 32'(highWater), 32'd0);
      if (j == 60) chk("R9 highWater at mark", 32'(highWater), 32'd1);
    end
    idle();
    chk("R8 fill saturates", 32'(fillLevel), 32'd64);
    chk("R2 varOut after run", 32'(varOut), 32'd70);
    rdOffset = 6'd0; #1;
    chk("R5 newest entry", 32'(histOut), 32'd69);
    rdOffset = 6'd63; #1;
    chk("R5 oldest entry", 32'(histOut), 32'd6);
    chk("R5 histValid full", 32'(histValid), 32'd1);

    // R6 full rewind with clkEn and force on the same edge
    rewindReq = 1; rewindN = 7'd64; clkEn = 1; varIn = 16'hBEEF;
    forceReq = 1; forceVal = 16'hABCD;
    step(); idle();
    chk("R6 full rewind value", 32'(varOut), 32'd6);
    chk("R6 full rewind fill", 32'(fillLevel), 32'd0);
    chk("R6 no error", 32'(rewindErr), 32'd0);

    // R7 refused rewind lets force proceed
    rewindReq = 1; rewindN = 7'd1; forceReq = 1; forceVal = 16'h1234;
    step(); idle();
    chk("R7 err pulse", 32'(rewindErr), 32'd1);
    chk("R4 force with refused rewind", 32'(varOut), 32'h1234);
    step();
    chk("R7 err clears", 32'(rewindErr), 32'd0);

    // R4 force with clkEn still records
    clkEn = 1; varIn = 16'h0F0F; forceReq = 1; forceVal = 16'h2222;
    step(); idle();
    rdOffset = '0; #1;
    chk("R4 force over step", 32'(varOut), 32'h2222);
    chk("R4 captured old", 32'(histOut), 32'h1234);
    chk("R4 fill", 32'(fillLevel), 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule